// File: doc/BRIEF.md
# Clock Source Controller with Interlocks

This block is the register-mapped control point for the high-speed and low-speed clock sources of a chip. Software turns the internal and external high-speed oscillators, the PLL and the two low-speed oscillators on and off. It picks which source drives the system clock, sets the PLL input and multiplier, and selects the real-time-clock source. Each source answers its enable with a "stable" input. The block turns that input into a ready flag, switches the system clock only onto a ready source, and raises an interrupt on the ready events that software has enabled.

The block refuses unsafe requests without reporting an error. A request to stop a source that feeds the system clock, directly or through the PLL, is dropped. The PLL settings are frozen while the PLL runs. The internal low-speed oscillator stays on while the watchdog runs. Once a real-time-clock source has been picked, it holds until the separate backup-domain reset.

Register map: address 0 holds the source control, address 1 the clock configuration, address 2 the interrupts, and address 3 the RTC selection and switch status. Writes take effect on the clock edge where `wr_en` is high. `rdata` is a combinational view of the register at `addr`.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the block is in its start state:
  - only the internal high-speed oscillator is enabled (`osc_en` = 5'b00001; bit order 0 internal HS, 1 external HS, 2 PLL, 3 internal LS, 4 external LS);
  - the system clock is the internal oscillator, with `sys_src` = 0 and `sys_stat` = 0x00;
  - `irq` = 0, `pll_mul` = 2, `rtc_src` = 0 and `ext_hs_bypass` = 0.
- R2: Configuration word bits [1:0] request the system source: 0 internal, 1 external, 2 PLL; code 3 is ignored.
  - `sys_src` and `sys_stat` move to the requested source only on the edge after that source is ready and enabled; until then the previous source is kept.
  - `sys_stat` reads 0x00, 0x04 or 0x08 for internal, external or PLL.
- R3: A control write (address 0) that would disable a high-speed oscillator has no effect on that oscillator while the oscillator drives the system clock directly or through the PLL. Control bit 0 enables the internal oscillator, and bits [2:1] set the external oscillator mode.
- R4: A control write that clears bit 3 (the PLL enable) has no effect while the PLL is the system clock.
- R5: PLL settings are written in configuration bits [7:6] and [11:8] and only apply while the PLL is disabled; at other times they are ignored.
  - Bits [7:6] set the PLL input: 0 internal/2, 1 external, 2 external/2, 3 ignored.
  - Bits [11:8] hold a code, and `pll_mul` = code+2, saturating at 16 for codes 14 and 15.
- R6: The external oscillator mode in control bits [2:1] is 0 off, 1 on or 2 bypass; mode 3 is ignored. Modes 1 and 2 set `osc_en[1]`, and only mode 2 sets `ext_hs_bypass`.
- R7: Control read bits [12:8] show the ready flags in `osc_en` bit order. A flag is high on the edge after both the source's enable and its stable input are high.
- R8: A ready interrupt is pending after a rising edge of a ready flag, provided interrupt register bits [4:0] enable that source.
  - Pending bits read at interrupt bits [15:11].
  - Writing 1 to the same bits [15:11] clears them; a new event in the same cycle wins over the clear.
  - `irq` is the OR of the pending bits.
- R9: RTC register bits [1:0] select the RTC source: 1 external LS, 2 internal LS, 3 external HS/128. A write is accepted only while the selection is 0. `bkp_rst_n` alone returns the selection to 0.
- R10: A control write clearing bit 4 (the internal low-speed enable) has no effect while `wdog_run` is high. Control bit 5 enables the external low-speed oscillator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low main reset |
| bkp_rst_n | input | 1 | Active-low backup-domain reset for the RTC selection |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| osc_stable | input | 5 | Per-source stable indication from the oscillator models |
| wdog_run | input | 1 | Watchdog running, which holds the internal low-speed oscillator |
| osc_en | output | 5 | Per-source enables |
| ext_hs_bypass | output | 1 | External oscillator bypassed by an external clock |
| pll_src | output | 2 | PLL input selection |
| pll_mul | output | 5 | PLL multiplication factor |
| sys_src | output | 2 | Active system clock source code |
| sys_stat | output | 8 | Switch status byte (0x00, 0x04, 0x08) |
| rtc_src | output | 2 | Locked RTC source selection |
| irq | output | 1 | Ready interrupt |

## Verification
A wrong interlock shows at `osc_en` on the edge after the offending write: an enable drops while `sys_src` still names that source, or while the source still feeds the PLL. A premature switch shows as `sys_stat` changing one cycle after the request, before the source model could have reported stable. A wrong edge detector or clear path leaves `irq` at the wrong level two edges after the ready flag rises, or one edge after a clear write. A broken RTC lock shows in `rtc_src` the edge after a second selection write.

// File: rtl/clkc_pkg.sv
package clkc_pkg;

  localparam int NSRC   = 5;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 4;
  localparam int MUL_W  = 5;
  localparam int STAT_W = 8;

  localparam int IHS = 0;
  localparam int EHS = 1;
  localparam int PLL = 2;
  localparam int ILS = 3;
  localparam int ELS = 4;

  localparam logic [1:0] SRC_INT = 2'd0;
  localparam logic [1:0] SRC_EXT = 2'd1;
  localparam logic [1:0] SRC_PLL = 2'd2;
  localparam logic [1:0] SRC_RSV = 2'd3;

  localparam logic [1:0] EXT_OFF = 2'd0;
  localparam logic [1:0] EXT_ON  = 2'd1;
  localparam logic [1:0] EXT_BYP = 2'd2;
  localparam logic [1:0] EXT_RSV = 2'd3;

  localparam logic [1:0] PIN_INT_HALF = 2'd0;
  localparam logic [1:0] PIN_EXT      = 2'd1;
  localparam logic [1:0] PIN_EXT_HALF = 2'd2;
  localparam logic [1:0] PIN_RSV      = 2'd3;

  typedef struct packed {
    logic       els;
    logic       ils;
    logic       pll;
    logic [1:0] ehs;
    logic       ihs;
  } ctrl_t;

  // multiplier from its code: code+2, saturating at 16
  function automatic logic [MUL_W-1:0] mul_of_code(input logic [CODE_W-1:0] code);
    if (code >= CODE_W'(14)) return MUL_W'(16);
    return MUL_W'(code) + MUL_W'(2);
  endfunction

  // switch status byte: source code placed two bits up
  function automatic logic [STAT_W-1:0] stat_of_src(input logic [1:0] src);
    return {4'b0000, src, 2'b00};
  endfunction

  function automatic logic pll_uses_ext(input logic [1:0] pin);
    return pin != PIN_INT_HALF;
  endfunction

endpackage

// File: rtl/clkc_rdy_irq.sv
module clkc_rdy_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic src_on,
  input  logic stable,
  input  logic irq_en,
  input  logic clr,
  output logic rdy,
  output logic pend
);

  logic rdy_d;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy   <= 1'b0;
      rdy_d <= 1'b0;
    end else begin
      rdy   <= src_on & stable;
      rdy_d <= rdy;
    end
  end

  assign rise = rdy & ~rdy_d;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend <= 1'b0;
    else if (rise && irq_en) pend <= 1'b1;
    else if (clr)            pend <= 1'b0;
  end

  AST_PEND_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(rise && irq_en)); // R8

  AST_RDY_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(src_on && stable)); // R7

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(rise && irq_en)) |=> !pend); // R8

endmodule

// File: rtl/clkc_sys_switch.sv
module clkc_sys_switch
  import clkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        req,
  input  logic [NSRC-1:0]   rdy_eff,
  output logic [1:0]        active,
  output logic [1:0]        nxt_active,
  output logic [STAT_W-1:0] stat
);

  logic tgt_rdy;
  logic sw_evt;

  always_comb begin
    case (req)
      SRC_INT: tgt_rdy = rdy_eff[IHS];
      SRC_EXT: tgt_rdy = rdy_eff[EHS];
      SRC_PLL: tgt_rdy = rdy_eff[PLL];
      default: tgt_rdy = 1'b0;
    endcase
  end

  assign sw_evt     = (req != active) && tgt_rdy;
  assign nxt_active = sw_evt ? req : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= SRC_INT;
    else        active <= nxt_active;
  end

  assign stat = stat_of_src(active);

  AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (active != $past(active)) |-> $past(tgt_rdy)); // R2

  AST_NO_RESERVED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    active != SRC_RSV); // R2

endmodule

// File: rtl/clkc_rtc_lock.sv
module clkc_rtc_lock (
  input  logic       clk,
  input  logic       bkp_rst_n,
  input  logic       wr,
  input  logic [1:0] sel_in,
  output logic [1:0] sel
);

  logic accept;

  assign accept = wr && (sel == 2'd0) && (sel_in != 2'd0);

  always_ff @(posedge clk or negedge bkp_rst_n) begin
    if (!bkp_rst_n)  sel <= 2'd0;
    else if (accept) sel <= sel_in;
  end

  AST_RTC_HELD: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (sel != 2'd0) |=> $stable(sel)); // R9

  AST_RTC_FIRST_PICK: assert property (@(posedge clk) disable iff (!bkp_rst_n)
    (wr && sel == 2'd0 && sel_in != 2'd0) |=> (sel == $past(sel_in))); // R9

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkp_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [NSRC-1:0]   osc_stable,
  input  logic              wdog_run,
  output logic [NSRC-1:0]   osc_en,
  output logic              ext_hs_bypass,
  output logic [1:0]        pll_src,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [1:0]        sys_src,
  output logic [STAT_W-1:0] sys_stat,
  output logic [1:0]        rtc_src,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RTC  = ADDR_W'(3);
  localparam int CLR_LSB = REG_W - NSRC;

  ctrl_t              ctrl_q;
  logic [1:0]         req_q;
  logic [1:0]         pin_q;
  logic [CODE_W-1:0]  code_q;
  logic [NSRC-1:0]    irqen_q;
  logic [NSRC-1:0]    rdy;
  logic [NSRC-1:0]    pend;
  logic [NSRC-1:0]    clr_vec;
  logic [NSRC-1:0]    rdy_eff;
  logic [1:0]         act;
  logic [1:0]         nxt_act;

  logic wr_ctrl, wr_cfg, wr_irq, wr_rtc;
  logic ihs_busy, ehs_busy, pll_busy;
  logic ihs_drop_blk, ehs_drop_blk, pll_drop_blk, ils_drop_blk;
  logic pll_cfg_blk;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign wr_irq  = wr_en && (addr == A_IRQ);
  assign wr_rtc  = wr_en && (addr == A_RTC);

  // in-use tests look at the source that will be active after this edge
  assign ihs_busy = (nxt_act == SRC_INT) || (nxt_act == SRC_PLL && !pll_uses_ext(pin_q));
  assign ehs_busy = (nxt_act == SRC_EXT) || (nxt_act == SRC_PLL && pll_uses_ext(pin_q));
  assign pll_busy = (nxt_act == SRC_PLL);

  assign ihs_drop_blk = wr_ctrl && !wdata[0] && ihs_busy;
  assign ehs_drop_blk = wr_ctrl && (wdata[2:1] == EXT_OFF) && ehs_busy;
  assign pll_drop_blk = wr_ctrl && !wdata[3] && pll_busy;
  assign ils_drop_blk = wr_ctrl && !wdata[4] && wdog_run;
  assign pll_cfg_blk  = wr_cfg && ctrl_q.pll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{els: 1'b0, ils: 1'b0, pll: 1'b0, ehs: EXT_OFF, ihs: 1'b1};
    end else if (wr_ctrl) begin
      if (!ihs_drop_blk) ctrl_q.ihs <= wdata[0];
      if (!ehs_drop_blk && wdata[2:1] != EXT_RSV) ctrl_q.ehs <= wdata[2:1];
      if (!pll_drop_blk) ctrl_q.pll <= wdata[3];
      if (!ils_drop_blk) ctrl_q.ils <= wdata[4];
      ctrl_q.els <= wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= SRC_INT;
      pin_q  <= PIN_INT_HALF;
      code_q <= '0;
    end else if (wr_cfg) begin
      if (wdata[1:0] != SRC_RSV) req_q <= wdata[1:0];
      if (!pll_cfg_blk) begin
        if (wdata[7:6] != PIN_RSV) pin_q <= wdata[7:6];
        code_q <= wdata[11:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irqen_q <= '0;
    else if (wr_irq) irqen_q <= wdata[NSRC-1:0];
  end

  assign clr_vec = wr_irq ? wdata[REG_W-1:CLR_LSB] : '0;

  assign osc_en[IHS] = ctrl_q.ihs;
  assign osc_en[EHS] = (ctrl_q.ehs != EXT_OFF);
  assign osc_en[PLL] = ctrl_q.pll;
  assign osc_en[ILS] = ctrl_q.ils;
  assign osc_en[ELS] = ctrl_q.els;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    clkc_rdy_irq u_rdy (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_on (osc_en[i]),
      .stable (osc_stable[i]),
      .irq_en (irqen_q[i]),
      .clr    (clr_vec[i]),
      .rdy    (rdy[i]),
      .pend   (pend[i])
    );
  end

  // a flag still high from before a disable must not attract a switch
  assign rdy_eff = rdy & osc_en;

  clkc_sys_switch u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_q),
    .rdy_eff    (rdy_eff),
    .active     (act),
    .nxt_active (nxt_act),
    .stat       (sys_stat)
  );

  clkc_rtc_lock u_rtc (
    .clk       (clk),
    .bkp_rst_n (bkp_rst_n),
    .wr        (wr_rtc),
    .sel_in    (wdata[1:0]),
    .sel       (rtc_src)
  );

  assign sys_src       = act;
  assign ext_hs_bypass = (ctrl_q.ehs == EXT_BYP);
  assign pll_src       = pin_q;
  assign pll_mul       = mul_of_code(code_q);
  assign irq           = |pend;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {3'b000, rdy, 2'b00, ctrl_q};
      A_CFG:   rdata = {4'b0000, code_q, pin_q, 4'b0000, req_q};
      A_IRQ:   rdata = {pend, 6'b000000, irqen_q};
      default: rdata = {sys_stat, 6'b000000, rtc_src};
    endcase
  end

  AST_INT_ACTIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_src == SRC_INT) |-> osc_en[IHS]); // R3

  AST_EXT_ACTIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_src == SRC_EXT) |-> osc_en[EHS]); // R3

  AST_PLL_FEED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ehs_busy && osc_en[EHS]) |=> osc_en[EHS]); // R3

  AST_PLL_ACTIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_src == SRC_PLL) |-> osc_en[PLL]); // R4

  AST_PLL_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.pll |=> $stable({pin_q, code_q})); // R5

  AST_EXT_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.ehs != EXT_RSV); // R6

  AST_ILS_WDOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_run && osc_en[ILS]) |=> osc_en[ILS]); // R10

endmodule

// File: tb/clk_src_ctrl_test.sv
module clk_src_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bkp_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  osc_stable;
  logic        wdog_run = 1'b0;
  logic [4:0]  osc_en;
  logic        ext_hs_bypass;
  logic [1:0]  pll_src;
  logic [4:0]  pll_mul;
  logic [1:0]  sys_src;
  logic [7:0]  sys_stat;
  logic [1:0]  rtc_src;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  clk_src_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bkp_rst_n(bkp_rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .osc_stable(osc_stable), .wdog_run(wdog_run),
    .osc_en(osc_en), .ext_hs_bypass(ext_hs_bypass), .pll_src(pll_src),
    .pll_mul(pll_mul), .sys_src(sys_src), .sys_stat(sys_stat), .rtc_src(rtc_src),
    .irq(irq)
  );

  // oscillator models: stable four edges after enable, drop at once
  logic [2:0] warm [5];
  for (genvar i = 0; i < 5; i++) begin : g_model
    always_ff @(posedge clk) begin
      if (!osc_en[i]) begin
        warm[i]       <= 3'd0;
        osc_stable[i] <= 1'b0;
      end else if (warm[i] == 3'd3) begin
        osc_stable[i] <= 1'b1;
      end else begin
        warm[i] <= warm[i] + 3'd1;
      end
    end
  end

  typedef struct packed {
    logic [1:0]  a;
    logic [15:0] d;
    logic [4:0]  en;
    logic [7:0]  st;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{2'd0, 16'h0003, 5'h03, 8'h00, 4'd6}, // R6 external on
    '{2'd1, 16'h0001, 5'h03, 8'h04, 4'd2}, // R2 switch to external
    '{2'd0, 16'h0002, 5'h02, 8'h04, 4'd3}, // R3 idle internal may stop
    '{2'd0, 16'h0000, 5'h02, 8'h04, 4'd3}, // R3 active external held
    '{2'd1, 16'h0741, 5'h02, 8'h04, 4'd5}, // R5 PLL from external, code 7
    '{2'd0, 16'h000A, 5'h06, 8'h04, 4'd4}, // PLL on
    '{2'd1, 16'h0742, 5'h06, 8'h08, 4'd2}, // R2 switch to PLL
    '{2'd0, 16'h0000, 5'h06, 8'h08, 4'd4}, // R4 PLL held, R3 its input held
    '{2'd0, 16'h0001, 5'h07, 8'h08, 4'd3}, // R3 internal back on
    '{2'd1, 16'h0000, 5'h07, 8'h00, 4'd2}, // R2 back to internal
    '{2'd0, 16'h0001, 5'h01, 8'h00, 4'd4}, // R4 PLL now free to stop
    '{2'd0, 16'h0031, 5'h19, 8'h00, 4'd10} // R10 low-speed pair on
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    idle(3);
    rst_n = 1'b1; bkp_rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 osc_en", 16'(osc_en), 16'h01);
    check("R1 sys_stat", 16'(sys_stat), 16'h00);
    check("R1 irq", 16'(irq), 16'h0);
    check("R1 pll_mul", 16'(pll_mul), 16'd2);
    check("R1 rtc_src", 16'(rtc_src), 16'h0);
    check("R1 bypass", 16'(ext_hs_bypass), 16'h0);
    idle(8);

    foreach (TBL[k]) begin
      wr(TBL[k].a, TBL[k].d);
      idle(12);
      check($sformatf("R%0d row%0d osc_en", TBL[k].req, k), 16'(osc_en), 16'(TBL[k].en));
      check($sformatf("R%0d row%0d sys_stat", TBL[k].req, k), 16'(sys_stat), 16'(TBL[k].st));
    end

    // R7 ready flags
    rd(2'd0, r);
    check("R7 ready flags", 16'(r[12:8]), 16'h19);

    // R5 PLL settings frozen while on, then saturation and reserved input
    check("R5 mul kept", 16'(pll_mul), 16'd9);
    check("R5 src kept", 16'(pll_src), 16'd1);
    wr(2'd1, 16'h0F00);
    idle(1);
    check("R5 code15 saturates", 16'(pll_mul), 16'd16);
    check("R5 src int/2", 16'(pll_src), 16'd0);
    wr(2'd1, 16'h00C0);
    idle(1);
    check("R5 reserved src ignored", 16'(pll_src), 16'd0);
    check("R5 code0", 16'(pll_mul), 16'd2);

    // R2 switch waits for readiness; code 3 ignored
    wr(2'd0, 16'h0033);
    wr(2'd1, 16'h0001);
    idle(1);
    check("R2 switch waits", 16'(sys_stat), 16'h00);
    idle(12);
    check("R2 switched ext", 16'(sys_stat), 16'h04);
    check("R2 sys_src ext", 16'(sys_src), 16'd1);
    wr(2'd1, 16'h0003);
    idle(4);
    check("R2 code3 ignored", 16'(sys_src), 16'd1);
    wr(2'd1, 16'h0000);
    idle(4);
    check("R2 back int", 16'(sys_stat), 16'h00);

    // R6 external modes
    wr(2'd0, 16'h0035);
    idle(1);
    check("R6 bypass", 16'(ext_hs_bypass), 16'h1);
    check("R6 bypass enabled", 16'(osc_en[1]), 16'h1);
    wr(2'd0, 16'h0037);
    idle(1);
    check("R6 mode3 ignored", 16'(ext_hs_bypass), 16'h1);
    wr(2'd0, 16'h0031);
    idle(8);
    check("R6 off", 16'(osc_en), 16'h19);
    check("R6 bypass cleared", 16'(ext_hs_bypass), 16'h0);

    // R8 interrupts
    wr(2'd2, 16'h0002);
    idle(2);
    check("R8 no event yet", 16'(irq), 16'h0);
    wr(2'd0, 16'h0033);
    idle(12);
    check("R8 irq raised", 16'(irq), 16'h1);
    wr(2'd0, 16'h003B);
    idle(12);
    rd(2'd2, r);
    check("R8 only enabled pending", 16'(r[15:11]), 16'h02);
    wr(2'd2, 16'h1002);
    idle(1);
    check("R8 cleared", 16'(irq), 16'h0);
    wr(2'd0, 16'h0031);
    idle(4);

    // R9 RTC lock
    wr(2'd3, 16'h0002);
    idle(1);
    check("R9 first pick", 16'(rtc_src), 16'd2);
    wr(2'd3, 16'h0001);
    idle(1);
    check("R9 locked", 16'(rtc_src), 16'd2);
    @(negedge clk); bkp_rst_n = 1'b0;
    idle(2); bkp_rst_n = 1'b1;
    idle(1);
    check("R9 backup reset", 16'(rtc_src), 16'd0);
    wr(2'd3, 16'h0003);
    idle(1);
    check("R9 repick", 16'(rtc_src), 16'd3);

    // R10 watchdog holds internal low-speed
    @(negedge clk); wdog_run = 1'b1;
    wr(2'd0, 16'h0021);
    idle(1);
    check("R10 ils held", 16'(osc_en[3]), 16'h1);
    @(negedge clk); wdog_run = 1'b0;
    wr(2'd0, 16'h0021);
    idle(1);
    check("R10 ils released", 16'(osc_en[3]), 16'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule